// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the management-port master of an Ethernet MAC. Software builds a complete 32-bit management frame, without its preamble, and writes it to the command register. That write starts the transaction. The block can first send a run of ones as a preamble. It then puts the frame on MDIO starting at the most significant bit. Each bit takes one period of MDC, and MDC is divided down from the system clock by a programmable amount.

For a read, the hardware releases the line for the turnaround bits and the data bits. It captures the sixteen bits returned by the PHY into the low half of the same command register. At the end of every frame a sticky completion flag is set, and software clears it by writing a one to it.

The divider and the preamble choice come from a control register. Both values are sampled when a frame starts, so a change to the control register during a frame has no effect on that frame.

Top module: `mii_mgmt_ctrl`

## Requirements
- R1: After reset, MDC is low, the output enable is low, the completion flag is 0, and all three registers read as zero: control at address 0, command at address 1, status at address 2.
- R2: A write to address 1 while idle starts a frame. The 32 written bits go out on MDIO starting at bit 31 and ending at bit 0, one bit per MDC period. Bits 31:28 hold start and opcode, 27:23 the PHY address, 22:18 the register address, 17:16 the turnaround, and 15:0 the data.
- R3: When control bit 7 is 1, 32 driven ones go out before bit 31 of the frame. When it is 0, the frame begins directly at bit 31.
- R4: Each MDC half-period lasts (div+1) system clocks, where div is control bits 6:0. MDC is low whenever no frame is in progress, and every bit starts with its low half.
- R5: MDIO takes the first bit in the cycle after the command write. It moves to the next bit only when MDC falls. Input data is sampled on the system clock edge where MDC rises.
- R6: A frame whose bits 29:28 equal binary 10 is a read. For a read, the output enable is low from frame bit 17 through frame bit 0. Every other frame bit and every preamble bit is driven with the output enable high.
- R7: On a read, frame bit k for k from 15 down to 0 is replaced by the MDIO input sampled on that bit's MDC rising edge. After the read, bits 31:16 of address 1 keep the values written. On a write frame, address 1 reads back the value written.
- R8: Completion sets bit 0 of address 2 on the final MDC falling edge, and the interrupt output follows that bit. Writing 1 to it clears it. Writing 0 to it leaves it unchanged.
- R9: A command write while a frame is in progress is ignored. The frame on the line and the readback of address 1 stay those of the running frame.
- R10: The divider and the preamble bit are sampled when a frame starts. A control write during the frame changes the value read back from address 0 but does not change the running frame's timing or preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for MDIO; 0 releases the line |
| mdio_i | input | 1 | Management data in |
| irq_o | output | 1 | Completion flag |

## Verification
The bench drives write frames and read frames through the same per-cycle model. This shows whether the release window depends on the opcode bits or on fixed timing. The divider is run at 0, 1, 2, 3 and 0x1F, with the preamble both on and off, to separate the half-period count from the bit count. The PHY data patterns are asymmetric (0x3C5A, 0x8001), so a capture into the wrong bit position or off by one edge shows up in the readback. Control and command writes made in the middle of a frame show whether the running frame is isolated from later register activity.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int FRAME_W   = 32;
  localparam int IDX_W     = $clog2(FRAME_W);
  localparam int DIV_W     = 7;
  localparam int PRE_BIT   = DIV_W;
  localparam int DATA_BITS = 16;
  localparam int TA_TOP    = DATA_BITS + 1;
  localparam int OP_LSB    = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMD  = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == div_i);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_q); // R4
  AST_MDC_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != div_i) |=> $stable(mdc_q)); // R4
endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
  import mii_mgmt_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] cmd_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               pre_en_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic [DIV_W-1:0]   div_o,
  output logic [FRAME_W-1:0] cmd_o,
  output logic               done_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_TOP);
  localparam logic [IDX_W-1:0] DATA_END = IDX_W'(DATA_BITS);

  logic               busy_q, pre_q, rd_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] cmd_q;
  logic [DIV_W-1:0]   div_q;
  logic               start, in_rel;

  assign start  = start_i && !busy_q;
  assign in_rel = !pre_q && rd_q && (idx_q <= TA_IDX);
  assign done_o = busy_q && fall_i && !pre_q && (idx_q == '0);

  assign busy_o    = busy_q;
  assign div_o     = div_q;
  assign cmd_o     = cmd_q;
  assign mdio_o    = !busy_q || pre_q || cmd_q[idx_q];
  assign mdio_oe_o = busy_q && !in_rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pre_q  <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      cmd_q  <= '0;
      div_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      pre_q  <= pre_en_i;
      rd_q   <= (cmd_i[OP_LSB+1:OP_LSB] == OP_READ);
      idx_q  <= LAST_IDX;
      cmd_q  <= cmd_i;
      div_q  <= div_i;
    end else if (busy_q) begin
      if (rise_i && in_rel && (idx_q < DATA_END))
        cmd_q[idx_q] <= mdio_i;
      if (fall_i) begin
        if (idx_q != '0) begin
          idx_q <= idx_q - 1'b1;
        end else if (pre_q) begin
          pre_q <= 1'b0;
          idx_q <= LAST_IDX;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  AST_MDIO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> ($stable(mdio_o) || !mdio_oe_o)); // R5
  AST_WR_FRAME_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rd_q) |=> $stable(cmd_q)); // R9
  AST_WR_ALL_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rd_q) |-> mdio_oe_o); // R6
endmodule

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs
  import mii_mgmt_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [FRAME_W-1:0] wdata_i,
  input  logic [FRAME_W-1:0] cmd_rd_i,
  input  logic               done_i,
  output logic [DIV_W-1:0]   div_o,
  output logic               pre_en_o,
  output logic               cmd_we_o,
  output logic               irq_o,
  output logic [FRAME_W-1:0] rdata_o
);
  logic [DIV_W-1:0] div_q;
  logic             pre_q, irq_q, clr;

  assign clr      = we_i && (addr_i == ADDR_STAT) && wdata_i[0];
  assign cmd_we_o = we_i && (addr_i == ADDR_CMD);
  assign div_o    = div_q;
  assign pre_en_o = pre_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_CTRL) begin
        div_q <= wdata_i[DIV_W-1:0];
        pre_q <= wdata_i[PRE_BIT];
      end
      if (done_i)   irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[DIV_W-1:0] = div_q;
        rdata_o[PRE_BIT]   = pre_q;
      end
      ADDR_CMD:  rdata_o = cmd_rd_i;
      ADDR_STAT: rdata_o[0] = irq_q;
      default:   rdata_o = '0;
    endcase
  end

  AST_IRQ_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(done_i)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr) |=> irq_q); // R8
endmodule

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i,
  output logic        irq_o
);
  logic [DIV_W-1:0]   div_reg, div_run;
  logic               pre_en, cmd_we, busy, done, rise, fall;
  logic [FRAME_W-1:0] cmd_cur;

  mii_mgmt_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .cmd_rd_i(cmd_cur), .done_i(done),
    .div_o(div_reg), .pre_en_o(pre_en), .cmd_we_o(cmd_we),
    .irq_o(irq_o), .rdata_o(bus_rdata_o)
  );

  mii_frame_engine #(.DIV_W(DIV_W)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd_we), .cmd_i(bus_wdata_i),
    .div_i(div_reg), .pre_en_i(pre_en), .rise_i(rise), .fall_i(fall),
    .mdio_i(mdio_i), .busy_o(busy), .div_o(div_run), .cmd_o(cmd_cur),
    .done_o(done), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  mii_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .div_i(div_run),
    .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );
endmodule

// File: tb/mii_mgmt_ctrl_tb.sv
module mii_mgmt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, mdoe, irq;
  logic        mdi = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [3:0] exp_q[$];  // {mdc, oe, out, phy_drive}

  always #2.5 clk = !clk;

  mii_mgmt_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(mdoe), .mdio_i(mdi), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        e = exp_q.pop_front();
        mdi = e[0];
        chk(mdc == e[3], "R4 mdc", 32'(mdc), 32'(e[3]));
        chk(mdoe == e[2], "R6 oe", 32'(mdoe), 32'(e[2]));
        if (e[2]) chk(mdo == e[1], "R2 mdio", 32'(mdo), 32'(e[1]));
      end else begin
        mdi = 1'b1;
        chk(mdc == 1'b0, "R4 idle mdc", 32'(mdc), 32'd0);
        chk(mdoe == 1'b0, "R6 idle oe", 32'(mdoe), 32'd0);
      end
    end
  end

  task automatic push_frame(input logic [31:0] cmd, input int div, input bit pre,
                            input logic [15:0] phy);
    bit rd;
    rd = (cmd[29:28] == 2'b10);
    if (pre)
      for (int b = 0; b < 32; b++)
        for (int h = 0; h < 2; h++)
          for (int c = 0; c <= div; c++) exp_q.push_back({h[0], 1'b1, 1'b1, 1'b0});
    for (int i = 31; i >= 0; i--) begin
      logic oe, ph;
      oe = !(rd && i <= 17);
      ph = (i < 16) ? phy[i] : 1'b0;
      for (int h = 0; h < 2; h++)
        for (int c = 0; c <= div; c++) exp_q.push_back({h[0], oe, cmd[i], ph});
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic launch(input logic [31:0] cmd, input int div, input bit pre,
                        input logic [15:0] phy);
    bus_wr(2'd1, cmd);
    push_frame(cmd, div, pre, phy);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy_a,
                                     input logic [4:0] reg_a, input logic [15:0] d);
    return {rd ? 4'h6 : 4'h5, phy_a, reg_a, 2'b10, d};
  endfunction

  initial begin
    logic [31:0] v, c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    bus_rd(2'd1, v); chk(v == 0, "R1 cmd", v, 0);
    bus_rd(2'd2, v); chk(v == 0, "R1 stat", v, 0);
    chk(irq == 0 && mdc == 0 && mdoe == 0, "R1 pins", {mdc, mdoe, irq}, 0);

    // R2 write frame, div 1, no preamble
    bus_wr(2'd0, 32'h01);
    c1 = mk(0, 5'd3, 5'd9, 16'hA5C3);
    launch(c1, 1, 0, 16'h0);
    wait_idle();
    chk(irq == 1'b1, "R8 irq set", 32'(irq), 1);
    bus_rd(2'd1, v); chk(v == c1, "R7 write readback", v, c1);
    bus_wr(2'd2, 32'h0);
    bus_rd(2'd2, v); chk(v == 1, "R8 write0 keeps", v, 1);
    bus_wr(2'd2, 32'h1);
    bus_rd(2'd2, v); chk(v == 0, "R8 w1c", v, 0);
    chk(irq == 1'b0, "R8 irq pin clear", 32'(irq), 0);

    // R6 R7 read frame, div 0
    bus_wr(2'd0, 32'h00);
    c1 = mk(1, 5'd1, 5'd2, 16'hFFFF);
    launch(c1, 0, 0, 16'h3C5A);
    wait_idle();
    bus_rd(2'd1, v); chk(v == {c1[31:16], 16'h3C5A}, "R7 read capture", v, {c1[31:16], 16'h3C5A});
    chk(irq == 1'b1, "R8 irq read", 32'(irq), 1);
    bus_wr(2'd2, 32'h1);

    // R3 preamble, read, div 2
    bus_wr(2'd0, 32'h82);
    c1 = mk(1, 5'd31, 5'd0, 16'h0000);
    launch(c1, 2, 1, 16'h8001);
    wait_idle();
    bus_rd(2'd1, v); chk(v == {c1[31:16], 16'h8001}, "R3 preamble read data", v, {c1[31:16], 16'h8001});
    bus_wr(2'd2, 32'h1);

    // R9 command during frame ignored
    bus_wr(2'd0, 32'h03);
    c1 = mk(0, 5'd7, 5'd21, 16'h1234);
    c2 = mk(1, 5'd2, 5'd4, 16'h0);
    launch(c1, 3, 0, 16'h0);
    repeat (20) @(negedge clk);
    bus_wr(2'd1, c2);
    wait_idle();
    bus_rd(2'd1, v); chk(v == c1, "R9 busy write ignored", v, c1);
    bus_wr(2'd2, 32'h1);

    // R10 control change during frame
    bus_wr(2'd0, 32'h01);
    c1 = mk(0, 5'd16, 5'd31, 16'h8421);
    launch(c1, 1, 0, 16'h0);
    repeat (10) @(negedge clk);
    bus_wr(2'd0, 32'h85);
    wait_idle();
    bus_rd(2'd0, v); chk(v == 32'h85, "R10 ctrl readback", v, 32'h85);
    bus_wr(2'd2, 32'h1);

    // R4 normal divider with preamble, write frame
    bus_wr(2'd0, 32'h9F);
    c1 = mk(0, 5'd5, 5'd1, 16'h5AA5);
    launch(c1, 31, 1, 16'h0);
    wait_idle();
    chk(irq == 1'b1, "R4 long frame done", 32'(irq), 1);
    bus_wr(2'd2, 32'h1);

    // R5 back-to-back, read at div 0
    bus_wr(2'd0, 32'h00);
    c1 = mk(1, 5'd9, 5'd3, 16'h0);
    launch(c1, 0, 0, 16'h6DB6);
    wait_idle();
    launch(c1, 0, 0, 16'h0F0F);
    wait_idle();
    bus_rd(2'd1, v); chk(v == {c1[31:16], 16'h0F0F}, "R5 second read", v, {c1[31:16], 16'h0F0F});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule